// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Controller

This block gathers the pending indications of a large bank of GPIO pins into a compact summary. Each summary bit stands for a group of four adjacent pins. The block raises one upstream interrupt line from that summary. Each pin counts as pending when either its interrupt status or its wake status is high. The summary is registered once per clock. Software reads it as two 32-bit words through a small register port.

The upstream line is not a plain copy of the summary. Once it rises it stays high, whatever the pins do, until software writes the end-of-interrupt bit of the control word. After that write the line drops. It rises again one cycle later if any group is still pending. Software therefore reads the two words, services the pins, and writes end-of-interrupt to re-arm the line. Detection in each pin and the decoding of the system bus are outside this block.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is high exactly when at least one of pins 4n, 4n+1, 4n+2 and 4n+3 has its interrupt status or its wake status high. The summary is registered, so it reflects the pin inputs as sampled at the previous clock edge.
- R2: A read at word address 0 returns summary bits 0 to 31, with bit n in data bit n.
- R3: A read at word address 1 returns summary bits 32 to 45 in data bits 0 to 13. Data bits 14 to 31 of that word always read as zero.
- R4: While the upstream line is low, it goes high on the clock edge after the registered summary becomes non-zero. It stays low while the summary is zero.
- R5: Once high, the upstream line stays high even if every pin stops pending, until an end-of-interrupt write arrives.
- R6: A write to word address 2 with data bit 0 set is the end-of-interrupt command, and it drives the line low at that clock edge. A write to address 2 with bit 0 clear changes nothing.
- R7: If the summary is still non-zero after an end-of-interrupt, the line goes high again on the next clock edge.
- R8: Word address 2 always reads as zero, because the end-of-interrupt bit clears itself. Address 3 reads as zero. Writes to addresses 0, 1 and 3 affect neither the summary nor the line.
- R9: After reset the upstream line is low and both summary words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_int_sts | input | 184 | Interrupt status of each pin |
| pin_wake_sts | input | 184 | Wake status of each pin |
| reg_addr | input | 2 | Word address: 0 low summary, 1 high summary, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; bit 0 at address 2 is end-of-interrupt |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
The bench sets the pins at both ends of a group (first and last pin) and at both ends of the bank. It also sets pins whose group falls on either side of the split between the two words. A design that grouped pins wrongly or split the words at the wrong bit would return pending bits in the wrong position.

The line is checked in three situations: after its pins have cleared, after a control write with bit 0 clear, and after an end-of-interrupt while a pin is still pending. A design that followed the level would drop the line too early. A design that needed a fresh edge would never raise it again.

Writes to the summary addresses are checked to confirm they neither clear the summary nor re-arm the line.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS     = 184,
  parameter int PINS_PER_BIT = 4,
  parameter int WORD_W       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_int_sts,
  input  logic [NUM_PINS-1:0] pin_wake_sts,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_out
);

  localparam int SUM_BITS = (NUM_PINS + PINS_PER_BIT - 1) / PINS_PER_BIT;
  localparam int PAD_PINS = SUM_BITS * PINS_PER_BIT;
  localparam int VIEW_W   = 2 * WORD_W;
  localparam int HI_USED  = SUM_BITS - WORD_W;
  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam int EOI_BIT = 0;

  logic [PAD_PINS-1:0] pend;
  logic [SUM_BITS-1:0] sum_d, sum_q;
  logic [VIEW_W-1:0]   view;
  logic                eoi_wr;
  logic                unused_wdata;

  generate
    if (PAD_PINS > NUM_PINS) begin : g_pad_pins
      assign pend = {{(PAD_PINS-NUM_PINS){1'b0}}, pin_int_sts | pin_wake_sts};
    end else begin : g_full_pins
      assign pend = pin_int_sts | pin_wake_sts;
    end

    for (genvar g = 0; g < SUM_BITS; g++) begin : g_group
      assign sum_d[g] = |pend[g*PINS_PER_BIT +: PINS_PER_BIT];
    end

    if (VIEW_W > SUM_BITS) begin : g_pad_view
      assign view = {{(VIEW_W-SUM_BITS){1'b0}}, sum_q};
    end else begin : g_full_view
      assign view = sum_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;

  assign eoi_wr       = reg_wr && (reg_addr == ADDR_CTL) && reg_wdata[EOI_BIT];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    case (reg_addr)
      ADDR_LO: reg_rdata = view[WORD_W-1:0];
      ADDR_HI: reg_rdata = view[VIEW_W-1:WORD_W];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      irq_out <= 1'b0;
    else if (eoi_wr) irq_out <= 1'b0;
    else if (|sum_q) irq_out <= 1'b1;

  AST_HIGH_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_HI) |-> (reg_rdata >> HI_USED) == '0); // R3
  AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTL) |-> reg_rdata == '0); // R8
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_wr) |=> irq_out); // R5
  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !irq_out); // R6
  AST_ARMED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !eoi_wr && (|sum_q)) |=> irq_out); // R7
  AST_QUIET_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !(|sum_q)) |=> !irq_out); // R4

endmodule

// File: tb/gpio_irq_summary_test.sv
`timescale 1ns/1ps
module gpio_irq_summary_test;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_int_sts = '0;
  logic [NP-1:0] pin_wake_sts = '0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_summary uut (
    .clk(clk), .rst_n(rst_n), .pin_int_sts(pin_int_sts), .pin_wake_sts(pin_wake_sts),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [63:0] exp_sum(input logic [NP-1:0] a, input logic [NP-1:0] b);
    logic [NP-1:0] v;
    logic [63:0] r;
    v = a | b;
    r = '0;
    for (int n = 0; n < 46; n++) r[n] = |v[4*n +: 4];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    pin_int_sts = '0; pin_wake_sts = '0;
    @(negedge clk);
    @(negedge clk);
    wr(2'd2, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(2'd0, d); check("R9 low word after reset", d, 32'h0);
    rd(2'd1, d); check("R9 high word after reset", d, 32'h0);
  endtask

  task automatic t_pattern(input string tag, input logic [NP-1:0] ia, input logic [NP-1:0] wa);
    logic [31:0] d;
    logic [63:0] e;
    pin_int_sts = ia; pin_wake_sts = wa;
    e = exp_sum(ia, wa);
    @(negedge clk);
    rd(2'd0, d); check({"R1 R2 low ", tag}, d, e[31:0]);
    rd(2'd1, d); check({"R1 R3 high ", tag}, d, e[63:32]);
  endtask

  task automatic t_summary();
    logic [NP-1:0] a, b;
    a = '0; a[0] = 1'b1; b = '0;
    t_pattern("pin0", a, b);
    a = '0; a[3] = 1'b1; a[4] = 1'b1;
    t_pattern("pins3_4", a, b);
    a = '0; b = '0; b[127] = 1'b1; b[128] = 1'b1;
    t_pattern("wake split", a, b);
    a = '0; a[183] = 1'b1; b = '0; b[180] = 1'b1; b[100] = 1'b1;
    t_pattern("top group", a, b);
    a = '1; b = '0;
    t_pattern("all int", a, b);
    a = '0; b = '1;
    t_pattern("all wake", a, b);
    clear_all();
  endtask

  task automatic t_line();
    pin_int_sts[50] = 1'b1;
    @(negedge clk);
    check("R4 irq not yet (summary edge)", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R4 irq rises", {31'b0, irq_out}, 32'h1);
    pin_int_sts[50] = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 irq held after pins clear", {31'b0, irq_out}, 32'h1);
    wr(2'd2, 32'hFFFF_FFFE);
    check("R6 control write without eoi", {31'b0, irq_out}, 32'h1);
    wr(2'd2, 32'h1);
    check("R6 eoi drops line", {31'b0, irq_out}, 32'h0);
    repeat (2) @(negedge clk);
    check("R4 stays low when idle", {31'b0, irq_out}, 32'h0);
    pin_wake_sts[183] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 wake pin raises line", {31'b0, irq_out}, 32'h1);
    wr(2'd2, 32'h1);
    check("R6 eoi with pending", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 re-assert after eoi", {31'b0, irq_out}, 32'h1);
    clear_all();
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    logic [63:0] e;
    logic [NP-1:0] a;
    a = '0; a[7] = 1'b1; a[140] = 1'b1;
    pin_int_sts = a;
    e = exp_sum(a, '0);
    repeat (2) @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h1);
    check("R8 status writes keep line", {31'b0, irq_out}, 32'h1);
    rd(2'd0, d); check("R8 low word after write", d, e[31:0]);
    rd(2'd1, d); check("R8 high word after write", d, e[63:32]);
    rd(2'd2, d); check("R8 control reads zero", d, 32'h0);
    rd(2'd3, d); check("R8 unmapped reads zero", d, 32'h0);
    clear_all();
    check("R8 clean after clear", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_summary();
    t_line();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule